// File: doc/BRIEF.md
# Eye Mask Position Sweep Controller

This block owns the position of a rectangular eye-diagram mask used by a link-quality monitor. It produces three select codes: a thermometer code that chooses one of seven threshold reference levels (the vertical size of the mask), and two one-hot codes that each choose one of fifteen sampling-phase positions. One phase code positions the early edge of the mask and the other positions the late edge, and each covers its own half of the eye. Because the two edges move independently, an eye that is not symmetric can still be mapped. A separate control bit selects whether the upper and lower thresholds are exchanged between the two comparators.

In manual use, each of the three positions advances by one on the rising edge of its own step request, and wraps to its first position after its last one. In scan mode, a single start request walks all 210 masks (7 levels × (15 + 15) phase positions). The scan holds each mask for a programmable number of cycles and reports the index of the mask it is on. A done flag rises after the final mask. The threshold DAC and the phase interpolators sit outside this block. It drives only their digital selects.

Top module: `eye_mask_sweep`

## Requirements
- R1: After reset, the level is 0 (`vref_therm_o` = 7'b0000001), both phase selects are one-hot at bit 0, `swap_o`, `scan_busy_o` and `scan_done_o` are 0, and `mask_idx_o` is 0.
- R2: A rising edge on `step_vert_i` raises the level L by one. Level L is shown as bits 0..L of `vref_therm_o` set and all higher bits clear.
- R3: A rising edge on `step_early_i` moves the single set bit of `early_sel_o` up by one position. `late_sel_o` and `vref_therm_o` do not change.
- R4: A rising edge on `step_late_i` moves the single set bit of `late_sel_o` up by one position. `early_sel_o` and `vref_therm_o` do not change.
- R5: A step at the last position wraps to the first: level 6 goes to 0, and phase bit 14 goes to bit 0.
- R6: A step request held high for several cycles advances its position only once.
- R7: `swap_o` equals `swap_i` as sampled at the previous clock edge.
- R8: A rising edge on `scan_start_i` starts a scan at mask 0, with `scan_busy_o` high. Mask k has level k/30. For r = k mod 30: when r < 15, the early phase is r and the late phase is 0; otherwise the early phase is 0 and the late phase is r−15. `mask_idx_o` shows k.
- R9: Each scanned mask is held for `dwell_i` cycles, sampled at start. A dwell value of 0 counts as 1.
- R10: After mask 209 has been held for its full dwell, `scan_busy_o` falls and `scan_done_o` rises. The selects keep the last mask (level 6, early 0, late 14), and `scan_done_o` stays high until the next scan start.
- R11: While a scan is busy, manual step requests and further start requests have no effect on the selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_vert_i | input | 1 | Step request for the threshold level |
| step_early_i | input | 1 | Step request for the early phase |
| step_late_i | input | 1 | Step request for the late phase |
| swap_i | input | 1 | Exchange upper and lower thresholds |
| scan_start_i | input | 1 | Start request for an automatic scan |
| dwell_i | input | 16 | Cycles spent on each mask during a scan |
| vref_therm_o | output | 7 | Thermometer select for the threshold level |
| early_sel_o | output | 15 | One-hot early phase select |
| late_sel_o | output | 15 | One-hot late phase select |
| swap_o | output | 1 | Registered threshold-swap control |
| mask_idx_o | output | 8 | Index of the current scanned mask |
| scan_busy_o | output | 1 | Scan in progress |
| scan_done_o | output | 1 | Scan finished after the last mask |

## Verification
Single step pulses on each input walk every position and past the wrap. This separates the three channels from each other and shows the thermometer shape and the one-hot shape at every code. A request held high for several cycles tells edge detection apart from level sensing. Full scans with dwell values of 2, 0 and 4 are checked cycle by cycle against a computed mask order: the dwell of 0 shows the minimum of one cycle, and the other values show exact dwell counting and the early-then-late ordering inside each level. A manual step injected during a scan, and steps taken after the scan has finished, show that scan control has priority and that the done flag is sticky.

// File: rtl/eye_mask_pkg.sv
package eye_mask_pkg;
  typedef enum logic [1:0] {
    SCAN_IDLE = 2'd0,
    SCAN_RUN  = 2'd1,
    SCAN_DONE = 2'd2
  } scan_state_e;
endpackage

// File: rtl/step_edge.sv
module step_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] fire_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= req_i[g];
    end
    assign fire_o[g] = req_i[g] & ~prev_q[g];
  end

  assign prev_o = prev_q;
endmodule

// File: rtl/pos_counter.sv
module pos_counter #(
  parameter int N = 15,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] pos_o
);
  logic [W-1:0] pos_q, pos_d;
  logic         pos_en;

  always_comb begin
    pos_en = load_i | inc_i;
    if (load_i)                      pos_d = load_val_i;
    else if (pos_q == W'(N - 1))     pos_d = '0;
    else                             pos_d = pos_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_en) pos_q <= pos_d;
  end

  assign pos_o = pos_q;

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i && pos_q == W'(N - 1)) |=> (pos_q == '0));
  assert_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q < W'(N));
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import eye_mask_pkg::*;
#(
  parameter int V_LEVELS  = 7,
  parameter int PH_LEVELS = 15,
  parameter int DWELL_W   = 16,
  localparam int NPH   = 2 * PH_LEVELS,
  localparam int NMASK = V_LEVELS * NPH,
  localparam int IW    = $clog2(NMASK),
  localparam int VW    = $clog2(V_LEVELS),
  localparam int PW    = $clog2(PH_LEVELS),
  localparam int HW    = $clog2(NPH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [DWELL_W-1:0] dwell_i,
  output logic               load_o,
  output logic [VW-1:0]      v_o,
  output logic [PW-1:0]      e_o,
  output logic [PW-1:0]      l_o,
  output logic [IW-1:0]      idx_o,
  output logic               busy_o,
  output logic               done_o
);
  scan_state_e        st_q, st_d;
  logic [IW-1:0]      idx_q, idx_d;
  logic [VW-1:0]      v_q, v_d;
  logic [HW-1:0]      ph_q, ph_d;
  logic [DWELL_W-1:0] dcnt_q, dcnt_d, len_q, len_d;
  logic               last_dwell, advance, finish;

  assign last_dwell = (dcnt_q == len_q - DWELL_W'(1));
  assign advance    = (st_q == SCAN_RUN) && last_dwell && (idx_q != IW'(NMASK - 1));
  assign finish     = (st_q == SCAN_RUN) && last_dwell && (idx_q == IW'(NMASK - 1));

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    v_d    = v_q;
    ph_d   = ph_q;
    dcnt_d = dcnt_q;
    len_d  = len_q;
    load_o = 1'b0;
    if (start_i && st_q != SCAN_RUN) begin
      st_d   = SCAN_RUN;
      idx_d  = '0;
      v_d    = '0;
      ph_d   = '0;
      dcnt_d = '0;
      len_d  = (dwell_i == '0) ? DWELL_W'(1) : dwell_i;
      load_o = 1'b1;
    end else if (advance) begin
      idx_d  = idx_q + IW'(1);
      dcnt_d = '0;
      if (ph_q == HW'(NPH - 1)) begin
        ph_d = '0;
        v_d  = v_q + VW'(1);
      end else begin
        ph_d = ph_q + HW'(1);
      end
      load_o = 1'b1;
    end else if (finish) begin
      st_d = SCAN_DONE;
    end else if (st_q == SCAN_RUN) begin
      dcnt_d = dcnt_q + DWELL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SCAN_IDLE;
      idx_q  <= '0;
      v_q    <= '0;
      ph_q   <= '0;
      dcnt_q <= '0;
      len_q  <= DWELL_W'(1);
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      v_q    <= v_d;
      ph_q   <= ph_d;
      dcnt_q <= dcnt_d;
      len_q  <= len_d;
    end
  end

  assign v_o    = v_d;
  assign e_o    = (ph_d < HW'(PH_LEVELS)) ? PW'(ph_d) : '0;
  assign l_o    = (ph_d < HW'(PH_LEVELS)) ? '0 : PW'(ph_d - HW'(PH_LEVELS));
  assign idx_o  = idx_q;
  assign busy_o = (st_q == SCAN_RUN);
  assign done_o = (st_q == SCAN_DONE);

  assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));
  assert_idx_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < IW'(NMASK));
  assert_dwell_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_dwell) |=> $stable(idx_q));
  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);
endmodule

// File: rtl/eye_mask_sweep.sv
module eye_mask_sweep #(
  parameter int V_LEVELS  = 7,
  parameter int PH_LEVELS = 15,
  parameter int DWELL_W   = 16
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      step_vert_i,
  input  logic                                      step_early_i,
  input  logic                                      step_late_i,
  input  logic                                      swap_i,
  input  logic                                      scan_start_i,
  input  logic [DWELL_W-1:0]                        dwell_i,
  output logic [V_LEVELS-1:0]                       vref_therm_o,
  output logic [PH_LEVELS-1:0]                      early_sel_o,
  output logic [PH_LEVELS-1:0]                      late_sel_o,
  output logic                                      swap_o,
  output logic [$clog2(V_LEVELS*2*PH_LEVELS)-1:0]   mask_idx_o,
  output logic                                      scan_busy_o,
  output logic                                      scan_done_o
);
  localparam int VW = $clog2(V_LEVELS);
  localparam int PW = $clog2(PH_LEVELS);

  logic [1:0]    rst_sync_q;
  logic          rst_s;
  logic [3:0]    req, fire, prev;
  logic          scan_load;
  logic [VW-1:0] v_pos, v_ld;
  logic [PW-1:0] e_pos, l_pos, e_ld, l_ld;
  logic          swap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  assign req = {scan_start_i, step_late_i, step_early_i, step_vert_i};

  step_edge #(.N(4)) u_edge (
    .clk(clk), .rst_n(rst_s), .req_i(req), .fire_o(fire), .prev_o(prev)
  );

  scan_seq #(.V_LEVELS(V_LEVELS), .PH_LEVELS(PH_LEVELS), .DWELL_W(DWELL_W)) u_seq (
    .clk(clk), .rst_n(rst_s), .start_i(fire[3]), .dwell_i(dwell_i),
    .load_o(scan_load), .v_o(v_ld), .e_o(e_ld), .l_o(l_ld),
    .idx_o(mask_idx_o), .busy_o(scan_busy_o), .done_o(scan_done_o)
  );

  pos_counter #(.N(V_LEVELS)) u_vpos (
    .clk(clk), .rst_n(rst_s), .inc_i(fire[0] & ~scan_busy_o),
    .load_i(scan_load), .load_val_i(v_ld), .pos_o(v_pos)
  );
  pos_counter #(.N(PH_LEVELS)) u_epos (
    .clk(clk), .rst_n(rst_s), .inc_i(fire[1] & ~scan_busy_o),
    .load_i(scan_load), .load_val_i(e_ld), .pos_o(e_pos)
  );
  pos_counter #(.N(PH_LEVELS)) u_lpos (
    .clk(clk), .rst_n(rst_s), .inc_i(fire[2] & ~scan_busy_o),
    .load_i(scan_load), .load_val_i(l_ld), .pos_o(l_pos)
  );

  for (genvar g = 0; g < V_LEVELS; g++) begin : g_therm
    assign vref_therm_o[g] = (v_pos >= VW'(g));
  end
  for (genvar g = 0; g < PH_LEVELS; g++) begin : g_onehot
    assign early_sel_o[g] = (e_pos == PW'(g));
    assign late_sel_o[g]  = (l_pos == PW'(g));
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) swap_q <= 1'b0;
    else        swap_q <= swap_i;
  end
  assign swap_o = swap_q;

  assert_therm_shape_R2: assert property (@(posedge clk) disable iff (!rst_s)
    vref_therm_o[0] && ((vref_therm_o & (vref_therm_o + V_LEVELS'(1))) == '0));
  assert_early_onehot_R3: assert property (@(posedge clk) disable iff (!rst_s)
    $countones(early_sel_o) == 1);
  assert_late_onehot_R4: assert property (@(posedge clk) disable iff (!rst_s)
    $countones(late_sel_o) == 1);
  assert_held_once_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (step_vert_i && prev[0] && !scan_load) |=> $stable(vref_therm_o));
  assert_swap_follow_R7: assert property (@(posedge clk) disable iff (!rst_s)
    1'b1 |=> (swap_o == $past(swap_i)));
  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_s)
    (scan_busy_o && !scan_load) |=> ($stable(early_sel_o) && $stable(late_sel_o)
                                     && $stable(vref_therm_o)));
endmodule

// File: tb/eye_mask_sweep_tb.sv
module eye_mask_sweep_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_vert_i = 1'b0, step_early_i = 1'b0, step_late_i = 1'b0;
  logic        swap_i = 1'b0, scan_start_i = 1'b0;
  logic [15:0] dwell_i = 16'd1;
  logic [6:0]  vref_therm_o;
  logic [14:0] early_sel_o, late_sel_o;
  logic        swap_o, scan_busy_o, scan_done_o;
  logic [7:0]  mask_idx_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int ev = 0, ee = 0, el = 0;
  bit summary_done = 0;

  always #10 clk = ~clk;

  eye_mask_sweep u_dut (
    .clk(clk), .rst_n(rst_n), .step_vert_i(step_vert_i), .step_early_i(step_early_i),
    .step_late_i(step_late_i), .swap_i(swap_i), .scan_start_i(scan_start_i),
    .dwell_i(dwell_i), .vref_therm_o(vref_therm_o), .early_sel_o(early_sel_o),
    .late_sel_o(late_sel_o), .swap_o(swap_o), .mask_idx_o(mask_idx_o),
    .scan_busy_o(scan_busy_o), .scan_done_o(scan_done_o)
  );

  function automatic logic [6:0] therm(int l);
    return 7'((1 << (l + 1)) - 1);
  endfunction
  function automatic logic [14:0] oneh(int p);
    return 15'(1 << p);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_pos(string req);
    chk(req, 32'(vref_therm_o), 32'(therm(ev)));
    chk(req, 32'(early_sel_o), 32'(oneh(ee)));
    chk(req, 32'(late_sel_o), 32'(oneh(el)));
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: step_vert_i = 1'b1;
      1: step_early_i = 1'b1;
      default: step_late_i = 1'b1;
    endcase
    @(negedge clk);
    step_vert_i = 1'b0; step_early_i = 1'b0; step_late_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk_pos("R1");
    chk("R1", 32'(swap_o), 0);
    chk("R1", 32'(scan_busy_o), 0);
    chk("R1", 32'(scan_done_o), 0);
    chk("R1", 32'(mask_idx_o), 0);
  endtask

  task automatic t_vert();
    for (int i = 0; i < 8; i++) begin
      pulse(0);
      ev = (ev + 1) % 7;
      chk_pos((ev == 0) ? "R5" : "R2");
    end
  endtask

  task automatic t_early();
    for (int i = 0; i < 16; i++) begin
      pulse(1);
      ee = (ee + 1) % 15;
      chk_pos((ee == 0) ? "R5" : "R3");
    end
  endtask

  task automatic t_late();
    for (int i = 0; i < 17; i++) begin
      pulse(2);
      el = (el + 1) % 15;
      chk_pos((el == 0) ? "R5" : "R4");
    end
  endtask

  task automatic t_hold();
    @(negedge clk);
    step_early_i = 1'b1;
    step_vert_i = 1'b1;
    repeat (5) @(negedge clk);
    step_early_i = 1'b0;
    step_vert_i = 1'b0;
    ee = (ee + 1) % 15;
    ev = (ev + 1) % 7;
    chk_pos("R6");
    @(negedge clk);
    chk_pos("R6");
  endtask

  task automatic t_swap();
    @(negedge clk); swap_i = 1'b1;
    @(negedge clk); chk("R7", 32'(swap_o), 1);
    swap_i = 1'b0;
    @(negedge clk); chk("R7", 32'(swap_o), 0);
  endtask

  task automatic t_scan(int d, bit inject);
    int len;
    len = (d == 0) ? 1 : d;
    @(negedge clk);
    dwell_i = 16'(d);
    scan_start_i = 1'b1;
    @(negedge clk);
    scan_start_i = 1'b0;
    for (int k = 0; k < 210; k++) begin
      for (int c = 0; c < len; c++) begin
        ev = k / 30;
        ee = ((k % 30) < 15) ? (k % 30) : 0;
        el = ((k % 30) < 15) ? 0 : (k % 30) - 15;
        chk_pos((c == 0) ? "R8" : "R9");
        chk("R8", 32'(mask_idx_o), 32'(k));
        chk("R8", 32'(scan_busy_o), 1);
        if (inject) begin
          if (k == 0 && c == 1) begin
            step_vert_i = 1'b1; step_early_i = 1'b1; scan_start_i = 1'b1;
          end
          if (k == 0 && c == 2) begin
            step_vert_i = 1'b0; step_early_i = 1'b0; scan_start_i = 1'b0;
          end
          if (k == 0 && c == 3) chk_pos("R11");
        end
        @(negedge clk);
      end
    end
    chk("R10", 32'(scan_busy_o), 0);
    chk("R10", 32'(scan_done_o), 1);
    chk("R10", 32'(mask_idx_o), 209);
    ev = 6; ee = 0; el = 14;
    chk_pos("R10");
  endtask

  task automatic t_done_sticky();
    repeat (3) @(negedge clk);
    chk("R10", 32'(scan_done_o), 1);
    pulse(1);
    ee = 1;
    chk_pos("R10");
    chk("R10", 32'(scan_done_o), 1);
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_vert();
    t_early();
    t_late();
    t_hold();
    t_swap();
    t_scan(2, 1'b0);
    t_scan(0, 1'b0);
    t_scan(4, 1'b1);
    t_done_sticky();
    finish_run();
  end
endmodule